// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Control Registers

This block holds the software-visible control state for two bus-master DMA channels. Each channel has three registers: a command byte, a status byte and a 32-bit descriptor table pointer. Software reaches them through a byte-addressed register port. The block turns command writes into one-cycle start and abort pulses for the DMA engine next to it. The start pulse carries the channel's descriptor pointer. A completion strobe from the drive side closes the transfer and raises the channel's interrupt bit.

Channel c owns the eight bytes from address 8*c. Its command byte sits at +0, its status byte at +2 (two bytes above the command byte), and its pointer at +4..+7, least significant byte first. Bytes +1 and +3 always read as zero, and writes to them are ignored. Writes carry a size code: 0 means byte, 1 means 16-bit and 2 means 32-bit. Data is right-justified in `wr_data`. Command bit 0 is start/stop and command bit 3 is the transfer direction. Status bit 0 is the read-only active flag, bit 1 the error flag and bit 2 the interrupt flag. All other status bits are plain storage. Every output is registered, so any effect of a write or strobe shows up in the cycle after the edge that takes it.

Top module: `bm_regfile`

## Requirements
- R1: After reset both status bytes read 0x60, and every command byte and pointer reads zero; `irq` is low.
- R2: A command write that takes start/stop from 0 to 1 sets that channel's active bit. It also raises `start_pulse[c]` for exactly one cycle, with `start_ptr` lane c holding the channel's pointer.
- R3: A command write that takes start/stop from 1 to 0 clears the active bit and raises `abort_pulse[c]` for one cycle.
- R4: While start/stop is 1 before a command write, the write leaves direction bit 3 at its old value.
- R5: Software writes never change status bit 0 (active).
- R6: Status bits 1 and 2 clear only when a 1 is written while they are set. Writing 0 keeps them, and software writes never set them.
- R7: Command and status writes take effect only with size code 0. Pointer writes take effect only with size code 2 at offset +4. Any other size leaves the register unchanged.
- R8: A pointer write stores the written word with bits 1:0 forced to zero.
- R9: A `dma_done[c]` strobe clears that channel's start/stop bit and active bit and sets its interrupt bit.
- R10: While `bm_enable` is low, writes change no register and issue no pulse.
- R11: `irq` is high exactly when at least one channel's interrupt bit (status bit 2) is set.
- R12: A completion strobe beats a same-cycle software write. The interrupt bit ends set even when a 1 is written to clear it, and a same-cycle start write issues no start pulse.
- R13: A read returns, one cycle after `rd_en`, the four bytes from `addr` upward, little-endian. Bytes past the last address read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bm_enable | input | 1 | Global bus-master enable; writes are ignored while low |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | 4 | Byte address into the register bank |
| wr_size | input | 2 | Write size code: 0 byte, 1 16-bit, 2 32-bit |
| wr_data | input | 32 | Right-justified write data |
| dma_done | input | 2 | Per-channel completion strobe from the drive side |
| rd_data | output | 32 | Registered read data |
| start_pulse | output | 2 | Per-channel one-cycle transfer start |
| abort_pulse | output | 2 | Per-channel one-cycle transfer abort |
| start_ptr | output | 64 | Descriptor pointer per channel, lane c at bits 32*c+31:32*c |
| irq | output | 1 | OR of both channels' interrupt bits |

## Verification
Start/stop is driven through each edge in turn: rising, falling, and a write that keeps it at 1. This separates a real start or abort from a plain rewrite, and shows whether the direction lock follows the old or the new start/stop value. Status writes use ones and zeros on the active, error and interrupt positions with the flags both clear and set, so a plain store, a set-on-one and a true write-one-to-clear each give a different readback. The completion strobe is sent alone, together with a clearing status write, and together with a starting command write, to show which source has priority. Wrong-sized writes, writes with the enable low, and reads near the top of the bank cover the decode edges.

// File: rtl/bm_pkg.sv
package bm_pkg;
  // register layout inside one channel's bank
  localparam int BANK_BYTES = 8;
  localparam int PTR_BYTES  = 4;
  localparam int PTR_W      = 8 * PTR_BYTES;
  localparam logic [2:0] OFF_CMD = 3'd0;
  localparam logic [2:0] OFF_STS = 3'd2;
  localparam logic [2:0] OFF_PTR = 3'd4;

  // command bits
  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 3;
  // status bits
  localparam int STS_ACT = 0;
  localparam int STS_ERR = 1;
  localparam int STS_INT = 2;
  localparam logic [7:0] STS_RESET = 8'h60;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xfer_size_e;
endpackage

// File: rtl/bm_chan.sv
module bm_chan
  import bm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we,
  input  logic             sts_we,
  input  logic             ptr_we,
  input  logic [7:0]       wbyte,
  input  logic [PTR_W-1:0] wword,
  input  logic             done,
  output logic [7:0]       cmd_q,
  output logic [7:0]       sts_q,
  output logic [PTR_W-1:0] ptr_q,
  output logic             int_next,
  output logic             start_p,
  output logic             abort_p,
  output logic [PTR_W-1:0] start_ptr
);
  logic [7:0]       cmd_n;
  logic [7:0]       sts_n;
  logic [PTR_W-1:0] ptr_n;
  logic             go;
  logic             stop;

  // a completion in the same cycle suppresses both edges of start/stop
  assign go   = cmd_we & ~cmd_q[CMD_RUN] &  wbyte[CMD_RUN] & ~done;
  assign stop = cmd_we &  cmd_q[CMD_RUN] & ~wbyte[CMD_RUN] & ~done;

  always_comb begin
    cmd_n = cmd_q;
    if (cmd_we) begin
      cmd_n = wbyte;
      if (cmd_q[CMD_RUN]) cmd_n[CMD_DIR] = cmd_q[CMD_DIR];
    end
    if (done) cmd_n[CMD_RUN] = 1'b0;
  end

  always_comb begin
    sts_n = sts_q;
    if (sts_we) begin
      sts_n          = wbyte;
      sts_n[STS_ACT] = sts_q[STS_ACT];
      sts_n[STS_ERR] = sts_q[STS_ERR] & ~wbyte[STS_ERR];
      sts_n[STS_INT] = sts_q[STS_INT] & ~wbyte[STS_INT];
    end
    if (go)   sts_n[STS_ACT] = 1'b1;
    if (stop) sts_n[STS_ACT] = 1'b0;
    if (done) begin
      sts_n[STS_ACT] = 1'b0;
      sts_n[STS_INT] = 1'b1;
    end
  end

  always_comb begin
    ptr_n = ptr_q;
    if (ptr_we) ptr_n = {wword[PTR_W-1:2], 2'b00};
  end

  assign int_next = sts_n[STS_INT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      sts_q     <= STS_RESET;
      ptr_q     <= '0;
      start_p   <= 1'b0;
      abort_p   <= 1'b0;
      start_ptr <= '0;
    end else begin
      cmd_q   <= cmd_n;
      sts_q   <= sts_n;
      ptr_q   <= ptr_n;
      start_p <= go;
      abort_p <= stop;
      if (go) start_ptr <= ptr_q;
    end
  end
endmodule

// File: rtl/bm_rdmux.sv
module bm_rdmux #(
  parameter int NBYTES = 16,
  parameter int LANES  = 4,
  localparam int AW    = $clog2(NBYTES)
) (
  input  logic [NBYTES-1:0][7:0] img,
  input  logic [AW-1:0]          addr,
  output logic [LANES*8-1:0]     data
);
  logic [AW:0] idx [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign idx[i] = {1'b0, addr} + (AW+1)'(i);
    always_comb begin
      data[i*8 +: 8] = 8'h00;
      if (idx[i] < (AW+1)'(NBYTES)) data[i*8 +: 8] = img[idx[i][AW-1:0]];
    end
  end
endmodule

// File: rtl/bm_regfile.sv
module bm_regfile
  import bm_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 32,
  localparam int NBYTES = NCH * BANK_BYTES,
  localparam int AW     = $clog2(NBYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bm_enable,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [AW-1:0]      addr,
  input  logic [1:0]         wr_size,
  input  logic [DW-1:0]      wr_data,
  input  logic [NCH-1:0]     dma_done,
  output logic [DW-1:0]      rd_data,
  output logic [NCH-1:0]     start_pulse,
  output logic [NCH-1:0]     abort_pulse,
  output logic [NCH*PTR_W-1:0] start_ptr,
  output logic               irq
);
  logic [NCH-1:0][7:0]       cmd_all;
  logic [NCH-1:0][7:0]       sts_all;
  logic [NCH-1:0][PTR_W-1:0] ptr_all;
  logic [NCH-1:0]            int_nx;
  logic [NBYTES-1:0][7:0]    img;
  logic [DW-1:0]             rd_mux;
  logic                      wr_ok;
  logic [2:0]                off;

  assign wr_ok = wr_en & bm_enable;
  assign off   = addr[2:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    if (NCH > 1) begin : g_dec
      assign sel = (addr[AW-1:3] == (AW-3)'(c));
    end else begin : g_one
      assign sel = 1'b1;
    end

    bm_chan u_chan (
      .clk       (clk),
      .rst       (rst),
      .cmd_we    (wr_ok & sel & (off == OFF_CMD) & (wr_size == SZ_BYTE)),
      .sts_we    (wr_ok & sel & (off == OFF_STS) & (wr_size == SZ_BYTE)),
      .ptr_we    (wr_ok & sel & (off == OFF_PTR) & (wr_size == SZ_WORD)),
      .wbyte     (wr_data[7:0]),
      .wword     (wr_data[PTR_W-1:0]),
      .done      (dma_done[c]),
      .cmd_q     (cmd_all[c]),
      .sts_q     (sts_all[c]),
      .ptr_q     (ptr_all[c]),
      .int_next  (int_nx[c]),
      .start_p   (start_pulse[c]),
      .abort_p   (abort_pulse[c]),
      .start_ptr (start_ptr[c*PTR_W +: PTR_W])
    );

    // byte image of this channel's bank
    assign img[c*BANK_BYTES + 0] = cmd_all[c];
    assign img[c*BANK_BYTES + 1] = 8'h00;
    assign img[c*BANK_BYTES + 2] = sts_all[c];
    assign img[c*BANK_BYTES + 3] = 8'h00;
    for (genvar b = 0; b < PTR_BYTES; b++) begin : g_pb
      assign img[c*BANK_BYTES + 4 + b] = ptr_all[c][b*8 +: 8];
    end
  end

  bm_rdmux #(.NBYTES(NBYTES), .LANES(DW/8)) u_rdmux (
    .img  (img),
    .addr (addr),
    .data (rd_mux)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_mux;
      irq <= |int_nx;
    end
  end
endmodule

// File: rtl/bm_regfile_chk.sv
module bm_regfile_chk
  import bm_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bm_enable,
  input logic [NCH-1:0]            dma_done,
  input logic [NCH-1:0]            start_pulse,
  input logic [NCH-1:0]            abort_pulse,
  input logic [NCH*PTR_W-1:0]      start_ptr,
  input logic                      irq,
  input logic [NCH-1:0][7:0]       cmd_v,
  input logic [NCH-1:0][7:0]       sts_v,
  input logic [NCH-1:0][PTR_W-1:0] ptr_v
);
  logic [NCH-1:0] ints;
  for (genvar c = 0; c < NCH; c++) begin : g_i
    assign ints[c] = sts_v[c][STS_INT];
  end

  // R11
  a_r11_irq_or: assert property (@(posedge clk) disable iff (rst)
    irq == (|ints));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R2
    a_r2_start_active: assert property (@(posedge clk) disable iff (rst)
      start_pulse[c] |-> (sts_v[c][STS_ACT] && cmd_v[c][CMD_RUN]
                          && start_ptr[c*PTR_W +: PTR_W] == ptr_v[c]));
    // R2
    a_r2_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
      start_pulse[c] |=> !start_pulse[c]);
    // R3
    a_r3_abort_idle: assert property (@(posedge clk) disable iff (rst)
      abort_pulse[c] |-> (!sts_v[c][STS_ACT] && !cmd_v[c][CMD_RUN]));
    // R4
    a_r4_dir_locked: assert property (@(posedge clk) disable iff (rst)
      cmd_v[c][CMD_RUN] |=> cmd_v[c][CMD_DIR] == $past(cmd_v[c][CMD_DIR]));
    // R5
    a_r5_active_only_by_start: assert property (@(posedge clk) disable iff (rst)
      $rose(sts_v[c][STS_ACT]) |-> start_pulse[c]);
    // R8
    a_r8_ptr_aligned: assert property (@(posedge clk) disable iff (rst)
      ptr_v[c][1:0] == 2'b00);
    // R9
    a_r9_done_closes: assert property (@(posedge clk) disable iff (rst)
      dma_done[c] |=> (sts_v[c][STS_INT] && !sts_v[c][STS_ACT]
                       && !cmd_v[c][CMD_RUN] && !start_pulse[c]));
    // R10
    a_r10_disabled_hold: assert property (@(posedge clk) disable iff (rst)
      (!bm_enable && !dma_done[c]) |=> ($stable(cmd_v[c]) && $stable(sts_v[c])
                                        && $stable(ptr_v[c]) && !start_pulse[c]
                                        && !abort_pulse[c]));
  end
endmodule

bind bm_regfile bm_regfile_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bm_enable   (bm_enable),
  .dma_done    (dma_done),
  .start_pulse (start_pulse),
  .abort_pulse (abort_pulse),
  .start_ptr   (start_ptr),
  .irq         (irq),
  .cmd_v       (cmd_all),
  .sts_v       (sts_all),
  .ptr_v       (ptr_all)
);

// File: tb/sim_bm_regfile.sv
module sim_bm_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bm_enable = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  wr_size = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  dma_done = '0;
  logic [31:0] rd_data;
  logic [1:0]  start_pulse;
  logic [1:0]  abort_pulse;
  logic [63:0] start_ptr;
  logic        irq;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  bm_regfile u0 (
    .clk(clk), .rst(rst), .bm_enable(bm_enable), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_size(wr_size), .wr_data(wr_data), .dma_done(dma_done),
    .rd_data(rd_data), .start_pulse(start_pulse), .abort_pulse(abort_pulse),
    .start_ptr(start_ptr), .irq(irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one write, returning at the falling edge after the capturing edge
  task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_size = sz; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic done_pulse(input logic [1:0] m);
    @(negedge clk);
    dma_done = m;
    @(negedge clk);
    dma_done = '0;
  endtask

  task automatic done_with_write(input logic [1:0] m, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    dma_done = m; wr_en = 1'b1; addr = a; wr_size = 2'd0; wr_data = d;
    @(negedge clk);
    dma_done = '0; wr_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'd0, d);  check("R1 ch0 cmd/sts", d, 32'h0060_0000);
    rd(4'd8, d);  check("R1 ch1 cmd/sts", d, 32'h0060_0000);
    rd(4'd4, d);  check("R1 ch0 ptr", d, 32'h0);
    rd(4'd12, d); check("R1 ch1 ptr", d, 32'h0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_pointer();
    logic [31:0] d;
    wr(4'd4, 2'd2, 32'h1234_5677);
    rd(4'd4, d); check("R8 ptr low bits cleared", d, 32'h1234_5674);
    wr(4'd4, 2'd0, 32'h0000_00FF);
    rd(4'd4, d); check("R7 byte write to ptr ignored", d, 32'h1234_5674);
    wr(4'd0, 2'd1, 32'h0000_0009);
    check("R7 half write no start", start_pulse, 2'b00);
    rd(4'd0, d); check("R7 half write to cmd ignored", d, 32'h0060_0000);
  endtask

  task automatic t_start_stop();
    logic [31:0] d;
    wr(4'd0, 2'd0, 32'h08);
    check("R2 no start without run edge", start_pulse, 2'b00);
    wr(4'd0, 2'd0, 32'h09);
    check("R2 start pulse", start_pulse, 2'b01);
    check("R2 start ptr", start_ptr[31:0], 32'h1234_5674);
    check("R3 no abort on start", abort_pulse, 2'b00);
    @(negedge clk);
    check("R2 start lasts one cycle", start_pulse, 2'b00);
    rd(4'd0, d); check("R2 active set", d, 32'h0061_0009);
    wr(4'd0, 2'd0, 32'h01);
    check("R2 rewrite of run gives no start", start_pulse, 2'b00);
    rd(4'd0, d); check("R4 dir locked while running", d, 32'h0061_0009);
    wr(4'd0, 2'd0, 32'h00);
    check("R3 abort pulse", abort_pulse, 2'b01);
    rd(4'd0, d); check("R3 stop clears active, R4 dir kept", d, 32'h0060_0008);
  endtask

  task automatic t_status_writes();
    logic [31:0] d;
    wr(4'd2, 2'd0, 32'h61);
    rd(4'd0, d); check("R5 active not settable", d, 32'h0060_0008);
    wr(4'd2, 2'd0, 32'h66);
    rd(4'd0, d); check("R6 error/int not settable", d, 32'h0060_0008);
  endtask

  task automatic t_completion();
    logic [31:0] d;
    wr(4'd12, 2'd2, 32'hABCD_EF00);
    wr(4'd8, 2'd0, 32'h01);
    check("R2 ch1 start pulse", start_pulse, 2'b10);
    check("R2 ch1 start ptr", start_ptr[63:32], 32'hABCD_EF00);
    done_pulse(2'b10);
    check("R11 irq after done", irq, 1);
    rd(4'd8, d); check("R9 done closes ch1", d, 32'h0064_0000);
    wr(4'd10, 2'd0, 32'h60);
    rd(4'd8, d); check("R6 writing 0 keeps int", d, 32'h0064_0000);
    wr(4'd10, 2'd0, 32'h64);
    rd(4'd8, d); check("R6 W1C clears int", d, 32'h0060_0000);
    check("R11 irq low after clear", irq, 0);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    done_pulse(2'b01);
    rd(4'd0, d); check("R9 done on idle ch0 sets int", d, 32'h0064_0008);
    done_with_write(2'b01, 4'd2, 32'h64);
    check("R12 irq stays set", irq, 1);
    rd(4'd0, d); check("R12 done beats W1C", d, 32'h0064_0008);
    wr(4'd2, 2'd0, 32'h64);
    rd(4'd0, d); check("R6 clear after collision", d, 32'h0060_0008);
    done_with_write(2'b01, 4'd0, 32'h09);
    check("R12 done suppresses start", start_pulse, 2'b00);
    rd(4'd0, d); check("R12 run stays clear", d, 32'h0064_0008);
    wr(4'd2, 2'd0, 32'h04);
    rd(4'd0, d); check("R6 W1C only int bit", d, 32'h0000_0008);
    wr(4'd2, 2'd0, 32'h60);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    bm_enable = 1'b0;
    wr(4'd0, 2'd0, 32'h09);
    check("R10 no start when disabled", start_pulse, 2'b00);
    wr(4'd4, 2'd2, 32'h5555_5554);
    rd(4'd0, d); check("R10 cmd unchanged", d, 32'h0060_0008);
    rd(4'd4, d); check("R10 ptr unchanged", d, 32'h1234_5674);
    bm_enable = 1'b1;
  endtask

  task automatic t_read_window();
    logic [31:0] d;
    rd(4'd6, d);  check("R13 window across banks", d, 32'h0000_1234);
    rd(4'd14, d); check("R13 past end reads zero", d, 32'h0000_ABCD);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pointer();
    t_start_stop();
    t_status_writes();
    t_completion();
    t_collision();
    t_disabled();
    t_read_window();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule